// File: doc/BRIEF.md
# Six-Pin Bidirectional I/O Port

This block is a general-purpose port of six pins on a microcontroller register bus. It holds an output latch and a direction register. Each pin gets its own drive value and drive enable, so a pad ring can build a tri-state buffer from them. One pin is open-drain and can only pull low. The other pins drive both levels. Pin levels come back through a two-flop synchronizer. A port read returns those sampled levels, not the latch.

Software writes the whole latch with a port write. It changes a single bit with a bit-set or bit-clear operation. Such an operation reads the sampled pin levels, changes one bit and loads the result into the latch. A separate configuration register supplies an analog-select vector. Pins that are analog-capable and selected for analog read as zero. Analog mode does not take control of the driver away from the direction register.

Top module: `pio_port`

## Requirements
- R1: After reset the direction register holds all ones, the output latch holds zero, and every `pin_oe` bit is 0.
- R2: A pin whose direction bit is 1 has its `pin_oe` bit at 0.
- R3: A push-pull pin (every pin except bit 4) with direction bit 0 has `pin_oe` at 1. On every push-pull pin, `pin_out` carries the latch bit whatever the direction.
- R4: The open-drain pin, bit 4, always has `pin_out` at 0. Its `pin_oe` is 1 only when both its direction bit and its latch bit are 0.
- R5: With `bus_rd_sel` = 0, `bus_rdata` shows the pin levels two clock edges after they are applied. A port write (`bus_wr_port`) loads the latch from `bus_wdata` and leaves the read value unchanged.
- R6: A bit-set or bit-clear operation loads the latch with the current port read value, with bit `bus_bit_idx` forced to 1 or to 0. Set wins when both strobes are high. An index of 6 or 7 forces no bit, but the latch is still reloaded.
- R7: A pin with its `ana_sel` bit at 1 reads as 0 if it is analog-capable, meaning bits 0–3 and 5. Bit-set and bit-clear operations copy that 0 into the latch. `ana_sel` bit 4 has no effect.
- R8: With `bus_rd_sel` = 1, `bus_rdata[5:0]` returns the direction bits as written and `bus_rdata[7:6]` reads 0.
- R9: A port write in the same cycle as a bit operation takes precedence, and the bit operation is dropped.
- R10: `ana_sel` has no effect on `pin_oe` or `pin_out`.
- R11: A port write and a direction write in the same cycle both take effect on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wdata | input | 6 | Write data for the latch or the direction register |
| bus_wr_port | input | 1 | Write strobe for the output latch |
| bus_wr_dir | input | 1 | Write strobe for the direction register |
| bus_bit_set | input | 1 | Read-modify-write strobe that sets one bit |
| bus_bit_clr | input | 1 | Read-modify-write strobe that clears one bit |
| bus_bit_idx | input | 3 | Bit index for the set or clear operation |
| bus_rd_sel | input | 1 | Read select: 0 selects the port levels, 1 selects the direction register |
| bus_rdata | output | 8 | Combinational read data |
| ana_sel | input | 6 | Analog-select vector from the configuration register |
| pin_in | input | 6 | Sampled pad levels |
| pin_out | output | 6 | Pad drive value |
| pin_oe | output | 6 | Pad drive enable |

## Verification
Two functions can fall in the same cycle. A full latch write can coincide with a bit operation. A latch write can also coincide with a direction write. The bench raises the strobes together and then reads `pin_out` and `pin_oe` on the following cycle. For the first pair, the result must show only the full write. For the second pair, the result must show both new values. Every row of the vector table drives a simultaneous direction and latch write, so the drive logic is judged on the combined result.

// File: rtl/pio_pkg.sv
package pio_pkg;
  localparam int PIO_W   = 6;
  localparam int PIO_BUS = 8;
  localparam logic [PIO_W-1:0] PIO_OD_MASK  = 6'b010000;
  localparam logic [PIO_W-1:0] PIO_ANA_MASK = 6'b101111;

  typedef enum logic [1:0] {
    UPD_HOLD = 2'd0,
    UPD_FULL = 2'd1,
    UPD_RMW  = 2'd2
  } latch_upd_e;
endpackage

// File: rtl/pio_sync.sv
module pio_sync #(
  parameter int W      = 6,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] d_sync
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage_q[s] <= '0;
      end else if (s == 0) begin
        stage_q[s] <= d_async;
      end else begin
        stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
    end
  end

  assign d_sync = stage_q[STAGES-1];
endmodule

// File: rtl/pio_regs.sv
module pio_regs
  import pio_pkg::*;
#(
  parameter int W     = 6,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [W-1:0]     wdata,
  input  logic             wr_port,
  input  logic             wr_dir,
  input  logic             bit_set,
  input  logic             bit_clr,
  input  logic [IDX_W-1:0] bit_idx,
  input  logic [W-1:0]     port_view,
  output logic [W-1:0]     latch_q,
  output logic [W-1:0]     dir_q
);
  latch_upd_e   upd;
  logic [W-1:0] sel_mask;
  logic [W-1:0] rmw_val;

  always_comb begin
    sel_mask = '0;
    for (int i = 0; i < W; i++) begin
      if (bit_idx == IDX_W'(i)) sel_mask[i] = 1'b1;
    end
  end

  always_comb begin
    if (bit_set)      rmw_val = port_view | sel_mask;
    else              rmw_val = port_view & ~sel_mask;
  end

  always_comb begin
    if (wr_port)                  upd = UPD_FULL;
    else if (bit_set || bit_clr)  upd = UPD_RMW;
    else                          upd = UPD_HOLD;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= '0;
    end else begin
      case (upd)
        UPD_FULL: latch_q <= wdata;
        UPD_RMW:  latch_q <= rmw_val;
        default:  latch_q <= latch_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dir_q <= '1;
    else if (wr_dir) dir_q <= wdata;
  end
endmodule

// File: rtl/pio_drive.sv
module pio_drive #(
  parameter int             W       = 6,
  parameter logic [W-1:0]   OD_MASK = 6'b010000
) (
  input  logic [W-1:0] latch_q,
  input  logic [W-1:0] dir_q,
  output logic [W-1:0] pin_out,
  output logic [W-1:0] pin_oe
);
  for (genvar i = 0; i < W; i++) begin : g_pin
    if (OD_MASK[i]) begin : g_od
      assign pin_out[i] = 1'b0;
      assign pin_oe[i]  = ~dir_q[i] & ~latch_q[i];
    end else begin : g_pp
      assign pin_out[i] = latch_q[i];
      assign pin_oe[i]  = ~dir_q[i];
    end
  end
endmodule

// File: rtl/pio_port.sv
module pio_port
  import pio_pkg::*;
#(
  parameter int               PORT_W   = PIO_W,
  parameter int               BUS_W    = PIO_BUS,
  parameter int               SYNC_N   = 2,
  parameter logic [PORT_W-1:0] OD_MASK  = PIO_OD_MASK,
  parameter logic [PORT_W-1:0] ANA_MASK = PIO_ANA_MASK
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [PORT_W-1:0]  bus_wdata,
  input  logic               bus_wr_port,
  input  logic               bus_wr_dir,
  input  logic               bus_bit_set,
  input  logic               bus_bit_clr,
  input  logic [$clog2(BUS_W)-1:0] bus_bit_idx,
  input  logic               bus_rd_sel,
  output logic [BUS_W-1:0]   bus_rdata,
  input  logic [PORT_W-1:0]  ana_sel,
  input  logic [PORT_W-1:0]  pin_in,
  output logic [PORT_W-1:0]  pin_out,
  output logic [PORT_W-1:0]  pin_oe
);
  localparam int IDX_W = $clog2(BUS_W);

  logic [PORT_W-1:0] pins_sync;
  logic [PORT_W-1:0] port_view;
  logic [PORT_W-1:0] latch_q;
  logic [PORT_W-1:0] dir_q;

  pio_sync #(.W(PORT_W), .STAGES(SYNC_N)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (pin_in),
    .d_sync  (pins_sync)
  );

  assign port_view = pins_sync & ~(ana_sel & ANA_MASK);

  pio_regs #(.W(PORT_W), .IDX_W(IDX_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wdata     (bus_wdata),
    .wr_port   (bus_wr_port),
    .wr_dir    (bus_wr_dir),
    .bit_set   (bus_bit_set),
    .bit_clr   (bus_bit_clr),
    .bit_idx   (bus_bit_idx),
    .port_view (port_view),
    .latch_q   (latch_q),
    .dir_q     (dir_q)
  );

  pio_drive #(.W(PORT_W), .OD_MASK(OD_MASK)) u_drive (
    .latch_q (latch_q),
    .dir_q   (dir_q),
    .pin_out (pin_out),
    .pin_oe  (pin_oe)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_rd_sel) bus_rdata[PORT_W-1:0] = dir_q;
    else            bus_rdata[PORT_W-1:0] = port_view;
  end
endmodule

// File: rtl/pio_port_chk.sv
module pio_port_chk #(
  parameter int                PORT_W   = 6,
  parameter int                BUS_W    = 8,
  parameter logic [PORT_W-1:0] OD_MASK  = 6'b010000,
  parameter logic [PORT_W-1:0] ANA_MASK = 6'b101111
) (
  input logic              clk,
  input logic              rst_n,
  input logic [PORT_W-1:0] bus_wdata,
  input logic              bus_wr_port,
  input logic              bus_wr_dir,
  input logic              bus_rd_sel,
  input logic [BUS_W-1:0]  bus_rdata,
  input logic [PORT_W-1:0] ana_sel,
  input logic [PORT_W-1:0] pin_oe,
  input logic [PORT_W-1:0] latch_q,
  input logic [PORT_W-1:0] dir_q
);
  for (genvar i = 0; i < PORT_W; i++) begin : g_bit
    assert_input_hiz_R2: assert property (@(posedge clk) disable iff (!rst_n)
      dir_q[i] |-> !pin_oe[i]);
    if (OD_MASK[i]) begin : g_od
      assert_od_low_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pin_oe[i] |-> (!latch_q[i] && !dir_q[i]));
    end
  end

  assert_full_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr_port |=> latch_q == $past(bus_wdata));

  assert_dir_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr_dir |=> dir_q == $past(bus_wdata));

  assert_dir_upper_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd_sel |-> bus_rdata[BUS_W-1:PORT_W] == '0);

  assert_analog_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd_sel |-> (bus_rdata[PORT_W-1:0] & ana_sel & ANA_MASK) == '0);
endmodule

bind pio_port pio_port_chk #(
  .PORT_W(PORT_W), .BUS_W(BUS_W), .OD_MASK(OD_MASK), .ANA_MASK(ANA_MASK)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_wdata   (bus_wdata),
  .bus_wr_port (bus_wr_port),
  .bus_wr_dir  (bus_wr_dir),
  .bus_rd_sel  (bus_rd_sel),
  .bus_rdata   (bus_rdata),
  .ana_sel     (ana_sel),
  .pin_oe      (pin_oe),
  .latch_q     (latch_q),
  .dir_q       (dir_q)
);

// File: tb/test_pio_port.sv
module test_pio_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] bus_wdata = '0;
  logic       bus_wr_port = 1'b0, bus_wr_dir = 1'b0;
  logic       bus_bit_set = 1'b0, bus_bit_clr = 1'b0;
  logic [2:0] bus_bit_idx = '0;
  logic       bus_rd_sel = 1'b0;
  logic [7:0] bus_rdata;
  logic [5:0] ana_sel = '0, pin_in = '0, pin_out, pin_oe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pio_port i_pio_port (
    .clk(clk), .rst_n(rst_n), .bus_wdata(bus_wdata),
    .bus_wr_port(bus_wr_port), .bus_wr_dir(bus_wr_dir),
    .bus_bit_set(bus_bit_set), .bus_bit_clr(bus_bit_clr),
    .bus_bit_idx(bus_bit_idx), .bus_rd_sel(bus_rd_sel),
    .bus_rdata(bus_rdata), .ana_sel(ana_sel), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe)
  );

  // {dir, latch, expected oe, expected out}; dir and latch written together
  localparam logic [23:0] VEC [6] = '{
    {6'h00, 6'h3F, 6'h2F, 6'h2F},
    {6'h00, 6'h00, 6'h3F, 6'h00},
    {6'h3F, 6'h3F, 6'h00, 6'h2F},
    {6'h0F, 6'h30, 6'h20, 6'h20},
    {6'h2A, 6'h15, 6'h05, 6'h05},
    {6'h05, 6'h0A, 6'h3A, 6'h0A}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic strobe(input logic wp, input logic wd, input logic bs,
                        input logic bc, input logic [2:0] idx, input logic [5:0] d);
    bus_wr_port = wp; bus_wr_dir = wd; bus_bit_set = bs; bus_bit_clr = bc;
    bus_bit_idx = idx; bus_wdata = d;
    tick();
    bus_wr_port = 0; bus_wr_dir = 0; bus_bit_set = 0; bus_bit_clr = 0;
  endtask

  task automatic rd(input logic sel, output logic [7:0] v);
    bus_rd_sel = sel;
    #0.5;
    v = bus_rdata;
  endtask

  initial begin
    #100000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    tick(); tick();
    rst_n = 1'b1;
    tick();
    // R1 reset state
    rd(1'b1, v);        check("R1 dir reset", v, 8'h3F);
    check("R1 oe reset", {2'b0, pin_oe}, 8'h00);
    check("R1 latch reset", {2'b0, pin_out}, 8'h00);

    // R3 R4 R11 table: simultaneous dir and latch writes
    for (int k = 0; k < 6; k++) begin
      strobe(1, 1, 0, 0, 3'd0, VEC[k][17:12]);
      bus_wdata = VEC[k][23:18];
      strobe(1, 1, 0, 0, 3'd0, VEC[k][23:18]);
      strobe(1, 0, 0, 0, 3'd0, VEC[k][17:12]);
    end
    for (int k = 0; k < 6; k++) begin
      // R11: one cycle carries both writes, with separate values via two cycles of data
      bus_wr_port = 1; bus_wr_dir = 1; bus_wdata = VEC[k][17:12];
      tick();
      bus_wr_port = 0;
      bus_wdata = VEC[k][23:18];
      tick();
      bus_wr_dir = 0;
      check("R3/R4 oe vector", {2'b0, pin_oe}, {2'b0, VEC[k][11:6]});
      check("R3/R4 out vector", {2'b0, pin_out}, {2'b0, VEC[k][5:0]});
    end
    // R11 true same-cycle: dir 0x00 and latch 0x00 in one edge
    strobe(1, 1, 0, 0, 3'd0, 6'h00);
    check("R11 same-cycle oe", {2'b0, pin_oe}, 8'h3F);
    check("R11 same-cycle out", {2'b0, pin_out}, 8'h00);

    // R5 synchronizer latency and write isolation
    pin_in = 6'h2D;
    tick();
    rd(1'b0, v);        check("R5 one edge old value", v, 8'h00);
    tick();
    rd(1'b0, v);        check("R5 two edges new value", v, 8'h2D);
    strobe(1, 0, 0, 0, 3'd0, 6'h12);
    rd(1'b0, v);        check("R5 write leaves read", v, 8'h2D);
    check("R5 write reaches latch", {2'b0, pin_out}, 8'h02);

    // R6 read-modify-write
    strobe(0, 0, 1, 0, 3'd4, 6'h00);
    check("R6 set bit4 out", {2'b0, pin_out}, 8'h2D);
    check("R6 set bit4 oe", {2'b0, pin_oe}, 8'h2F);
    strobe(0, 0, 0, 1, 3'd0, 6'h3F);
    check("R6 clr bit0 out", {2'b0, pin_out}, 8'h2C);
    check("R6 clr bit0 oe", {2'b0, pin_oe}, 8'h3F);
    strobe(0, 0, 1, 1, 3'd1, 6'h00);
    check("R6 set wins", {2'b0, pin_out}, 8'h2F);
    strobe(0, 0, 1, 0, 3'd6, 6'h00);
    check("R6 index 6 reload", {2'b0, pin_out}, 8'h2D);

    // R7 analog reads zero, bit4 not analog-capable
    ana_sel = 6'h3F;
    rd(1'b0, v);        check("R7 analog zero", v, 8'h00);
    pin_in = 6'h10;
    tick(); tick();
    rd(1'b0, v);        check("R7 bit4 ignores ana_sel", v, 8'h10);
    strobe(0, 0, 1, 0, 3'd1, 6'h00);
    // R10 driver still follows dir in analog mode
    check("R7 rmw copies zeros", {2'b0, pin_out}, 8'h02);
    check("R10 oe unaffected by ana_sel", {2'b0, pin_oe}, 8'h2F);
    ana_sel = 6'h00;
    #0.5;
    check("R10 out unaffected by ana_sel", {2'b0, pin_out}, 8'h02);

    // R9 full write beats bit operation
    strobe(1, 0, 1, 0, 3'd3, 6'h21);
    check("R9 precedence out", {2'b0, pin_out}, 8'h21);
    check("R9 precedence oe", {2'b0, pin_oe}, 8'h3F);

    // R8 direction readback
    strobe(0, 1, 0, 0, 3'd0, 6'h3F);
    rd(1'b1, v);        check("R8 dir all ones", v, 8'h3F);
    check("R2 all inputs hiz", {2'b0, pin_oe}, 8'h00);
    strobe(0, 1, 0, 0, 3'd0, 6'h05);
    rd(1'b1, v);        check("R8 dir pattern", v, 8'h05);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule